// File: doc/BRIEF.md
# Single-Channel Up-Counting Timer

This block is a 16-bit timer that counts upward. It has a programmable prescaler, a period limit and one channel that captures or compares. Software reaches every setting through a simple word-wide register port with a request strobe. Reads are combinational from the address. Writes take effect on the clock edge that samples the request.

When the count reaches the period, the counter returns to zero and raises an overflow event. Software can also raise this event by writing the software event register. The overflow event sets a status flag and loads the prescaler, period and compare values that are held in shadow registers. In one-cycle mode it also stops the counter.

The channel works in one of two modes. In capture mode it stores the counter value on a selected edge of a sampled input pin. In compare mode it drives a level output from a comparison of the counter with the compare value. In both modes, capture or match sets a channel flag, and each flag can drive the interrupt line.

Top module: `gp_timer`

Register word offsets, by byte address:

- Control at 0x00:
  - bit0: count enable
  - bit1: suppress overflow events
  - bit2: counter-only source
  - bit3: one-cycle mode
  - bit7: period buffering
  - bits 9:8: input sampling divide
- Interrupt enable at 0x0C: bit0 for overflow, bit1 for the channel.
- Status at 0x10: bit0 is the overflow flag, bit1 is the channel flag.
- Software event at 0x14: bit0.
- Channel mode at 0x18: bit0 selects capture mode, bit3 enables compare buffering.
- Channel control at 0x20: bit0 enables the channel, bit1 sets polarity.
- Counter at 0x24.
- Prescaler at 0x28.
- Period at 0x2C.
- Channel data at 0x34.

## Requirements
- R1: After reset every register reads 0, and cmp_o and irq_o are 0.
- R2: Unassigned bits read 0 and ignore writes. Any address other than the ten offsets reads 0. The software event register always reads 0.
- R3: While enabled, the counter advances once every (prescaler + 1) clocks. A step taken from a value at or above the active period goes to 0 instead.
- R4: An overflow event sets status bit0. Writing 0 to a status bit clears it, and writing 1 leaves it unchanged. irq_o is 1 exactly when some status bit is set together with its enable bit.
- R5: With control bit7 clear, a period write takes effect immediately. With bit7 set, the new period applies only from the next overflow event.
- R6: With control bit3 set, an overflow event clears the count enable bit (control bit0), so the counter stops at 0.
- R7: A write of 1 to software event bit0 resets the counter and prescaler and raises an overflow event, provided control bits 1 and 2 are both 0. Otherwise the write changes nothing. With control bit1 set, the counter still wraps but no overflow flag is set.
- R8: A written prescaler value is used only from the next overflow event. It reads back at once.
- R9: In capture mode (mode bit0 = 1) with the channel enabled, a sampled rising edge of cap_i stores the counter into channel data and sets status bit1. With polarity bit1 = 1, a falling edge does this instead. Writes to channel data are ignored in capture mode.
- R10: Control bits 9:8 sample cap_i every clock (00 or 11), every 2nd clock (01) or every 4th clock (10). With a divide of 4, exactly one of four one-clock pulses spaced 9 clocks apart is seen.
- R11: In compare mode with the channel enabled, cmp_o = (counter < compare), inverted when polarity is 1. In every other case cmp_o = 0.
- R12: With mode bit3 clear, a channel data write sets the compare value immediately. With bit3 set, it applies from the next overflow event, though it reads back at once.
- R13: In compare mode with the channel enabled, a counter step onto the compare value sets status bit1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Register access strobe |
| we_i | input | 1 | Write when 1, read when 0 |
| addr_i | input | 8 | Byte address of the register word |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i |
| cap_i | input | 1 | Capture input pin |
| cmp_o | output | 1 | Compare output pin |
| irq_o | output | 1 | Interrupt request |

## Verification
The hardest case to reach from the ports is the input sampling divide. Whether a one-clock pulse is seen depends on the phase of a free-running sample counter that the ports cannot read. The stimulus sends pulses spaced 9 clocks apart, which is 1 modulo 4, so four consecutive pulses meet every sampling phase exactly once. The bench then expects exactly one capture at a divide of 4 and four captures with no divide. The buffered-versus-live cases for the period, prescaler and compare value are also checked: the stopped counter is preset to a value that tells the old setting from the new one, and then stepped a known number of clocks.

// File: rtl/gp_timer_pkg.sv
package gp_timer_pkg;
  localparam logic [7:0] A_CTRL  = 8'h00;
  localparam logic [7:0] A_IEN   = 8'h0C;
  localparam logic [7:0] A_STS   = 8'h10;
  localparam logic [7:0] A_SWEV  = 8'h14;
  localparam logic [7:0] A_MODE  = 8'h18;
  localparam logic [7:0] A_CHCTL = 8'h20;
  localparam logic [7:0] A_CNT   = 8'h24;
  localparam logic [7:0] A_PSC   = 8'h28;
  localparam logic [7:0] A_PER   = 8'h2C;
  localparam logic [7:0] A_CDAT  = 8'h34;

  typedef struct packed {
    logic [1:0] flt_div;
    logic       per_buf;
    logic       one_shot;
    logic       src_sel;
    logic       ovf_dis;
    logic       cnt_en;
  } ctrl_t;

  typedef struct packed {
    logic cmp_buf;
    logic in_mode;
  } mode_t;

  typedef struct packed {
    logic pol;
    logic ch_en;
  } chctl_t;
endpackage

// File: rtl/gp_timer_cnt.sv
module gp_timer_cnt #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             ovf_dis_i,
  input  logic             src_sel_i,
  input  logic             sw_req_i,
  input  logic [CNT_W-1:0] per_i,
  input  logic [CNT_W-1:0] psc_i,
  input  logic             cnt_wr_i,
  input  logic [CNT_W-1:0] cnt_wdata_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] cnt_nxt_o,
  output logic             step_o,
  output logic             ev_o
);
  logic [CNT_W-1:0] cnt_q, psc_q, psc_nxt;
  logic tick, hw_ovf, sw_acc;

  assign tick   = en_i && (psc_q == psc_i);
  assign hw_ovf = tick && (cnt_q >= per_i);
  assign sw_acc = sw_req_i && !ovf_dis_i && !src_sel_i;
  assign ev_o   = (hw_ovf && !ovf_dis_i) || sw_acc;
  assign step_o = tick && !cnt_wr_i && !sw_acc;

  always_comb begin
    if (cnt_wr_i)    cnt_nxt_o = cnt_wdata_i;
    else if (sw_acc) cnt_nxt_o = '0;
    else if (tick)   cnt_nxt_o = hw_ovf ? '0 : cnt_q + 1'b1;
    else             cnt_nxt_o = cnt_q;
  end

  always_comb begin
    if (sw_acc)    psc_nxt = '0;
    else if (tick) psc_nxt = '0;
    else if (en_i) psc_nxt = psc_q + 1'b1;
    else           psc_nxt = psc_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      psc_q <= '0;
    end else begin
      cnt_q <= cnt_nxt_o;
      psc_q <= psc_nxt;
    end
  end

  assign cnt_o = cnt_q;

  // R3
  psc_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    psc_q <= psc_i);
endmodule

// File: rtl/gp_timer_chan.sv
module gp_timer_chan #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cap_i,
  input  logic [1:0]       flt_div_i,
  input  logic             in_mode_i,
  input  logic             ch_en_i,
  input  logic             pol_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] cmp_i,
  input  logic             step_i,
  input  logic [CNT_W-1:0] cnt_nxt_i,
  output logic             cap_evt_o,
  output logic             match_o,
  output logic             cmp_o
);
  localparam int unsigned DIV_W = 2;

  logic s1_q, s2_q, samp_q, samp_en, edge_hit;
  logic [DIV_W-1:0] div_q;

  always_comb begin
    unique case (flt_div_i)
      2'b01:   samp_en = ~div_q[0];
      2'b10:   samp_en = (div_q == '0);
      default: samp_en = 1'b1;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q   <= 1'b0;
      s2_q   <= 1'b0;
      samp_q <= 1'b0;
      div_q  <= '0;
    end else begin
      s1_q  <= cap_i;
      s2_q  <= s1_q;
      div_q <= div_q + 1'b1;
      if (samp_en) samp_q <= s2_q;
    end
  end

  assign edge_hit  = pol_i ? (samp_q & ~s2_q) : (~samp_q & s2_q);
  assign cap_evt_o = in_mode_i & ch_en_i & samp_en & edge_hit;
  assign match_o   = ~in_mode_i & ch_en_i & step_i & (cnt_nxt_i == cmp_i);
  assign cmp_o     = ~in_mode_i & ch_en_i & ((cnt_i < cmp_i) ^ pol_i);

  // R10
  samp_div4_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flt_div_i == 2'b10 && samp_en && $past(flt_div_i) == 2'b10) |=> !samp_en);
endmodule

// File: rtl/gp_timer_regs.sv
module gp_timer_regs
  import gp_timer_pkg::*;
#(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned AW    = 8,
  parameter int unsigned DW    = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             we_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [DW-1:0]    wdata_i,
  output logic [DW-1:0]    rdata_o,
  input  logic             ev_i,
  input  logic             cap_evt_i,
  input  logic             match_i,
  input  logic [CNT_W-1:0] cnt_i,
  output ctrl_t            ctrl_o,
  output mode_t            mode_o,
  output chctl_t           chctl_o,
  output logic [CNT_W-1:0] per_act_o,
  output logic [CNT_W-1:0] psc_act_o,
  output logic [CNT_W-1:0] cmp_act_o,
  output logic             cnt_wr_o,
  output logic [CNT_W-1:0] cnt_wdata_o,
  output logic             sw_req_o,
  output logic             irq_o
);
  localparam int unsigned FLG_N = 2;

  ctrl_t  ctrl_q;
  mode_t  mode_q;
  chctl_t chctl_q;
  logic [FLG_N-1:0] ien_q, sts_q;
  logic [CNT_W-1:0] per_q, psc_q, cdat_q, per_act_q, psc_act_q, cmp_act_q;
  logic wr, wr_ctrl, wr_ien, wr_sts, wr_mode, wr_chctl, wr_per, wr_psc, wr_cdat;
  logic unused_wdata;

  assign wr       = req_i & we_i;
  assign wr_ctrl  = wr && addr_i == A_CTRL;
  assign wr_ien   = wr && addr_i == A_IEN;
  assign wr_sts   = wr && addr_i == A_STS;
  assign wr_mode  = wr && addr_i == A_MODE;
  assign wr_chctl = wr && addr_i == A_CHCTL;
  assign wr_per   = wr && addr_i == A_PER;
  assign wr_psc   = wr && addr_i == A_PSC;
  assign wr_cdat  = wr && addr_i == A_CDAT && !mode_q.in_mode;
  assign cnt_wr_o    = wr && addr_i == A_CNT;
  assign cnt_wdata_o = wdata_i[CNT_W-1:0];
  assign sw_req_o    = wr && addr_i == A_SWEV && wdata_i[0];
  assign unused_wdata = ^wdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q    <= '0;
      mode_q    <= '0;
      chctl_q   <= '0;
      ien_q     <= '0;
      sts_q     <= '0;
      per_q     <= '0;
      psc_q     <= '0;
      cdat_q    <= '0;
      per_act_q <= '0;
      psc_act_q <= '0;
      cmp_act_q <= '0;
    end else begin
      if (wr_ctrl) ctrl_q <= '{flt_div: wdata_i[9:8], per_buf: wdata_i[7],
                               one_shot: wdata_i[3], src_sel: wdata_i[2],
                               ovf_dis: wdata_i[1], cnt_en: wdata_i[0]};
      if (ev_i && ctrl_q.one_shot) ctrl_q.cnt_en <= 1'b0;
      if (wr_mode)  mode_q  <= '{cmp_buf: wdata_i[3], in_mode: wdata_i[0]};
      if (wr_chctl) chctl_q <= '{pol: wdata_i[1], ch_en: wdata_i[0]};
      if (wr_ien)   ien_q   <= wdata_i[FLG_N-1:0];
      // flags: write 0 clears, hardware set wins
      if (wr_sts)    sts_q    <= sts_q & wdata_i[FLG_N-1:0];
      if (ev_i)      sts_q[0] <= 1'b1;
      if (cap_evt_i || match_i) sts_q[1] <= 1'b1;
      if (wr_per) begin
        per_q <= wdata_i[CNT_W-1:0];
        if (!ctrl_q.per_buf) per_act_q <= wdata_i[CNT_W-1:0];
      end
      if (wr_psc) psc_q <= wdata_i[CNT_W-1:0];
      if (wr_cdat) begin
        cdat_q <= wdata_i[CNT_W-1:0];
        if (!mode_q.cmp_buf) cmp_act_q <= wdata_i[CNT_W-1:0];
      end
      if (cap_evt_i) cdat_q <= cnt_i;
      if (ev_i) begin
        per_act_q <= per_q;
        psc_act_q <= psc_q;
        cmp_act_q <= cdat_q;
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      A_CTRL:  rdata_o = DW'({ctrl_q.flt_div, ctrl_q.per_buf, 3'b000, ctrl_q.one_shot,
                              ctrl_q.src_sel, ctrl_q.ovf_dis, ctrl_q.cnt_en});
      A_IEN:   rdata_o = DW'(ien_q);
      A_STS:   rdata_o = DW'(sts_q);
      A_MODE:  rdata_o = DW'({mode_q.cmp_buf, 2'b00, mode_q.in_mode});
      A_CHCTL: rdata_o = DW'({chctl_q.pol, chctl_q.ch_en});
      A_CNT:   rdata_o = DW'(cnt_i);
      A_PSC:   rdata_o = DW'(psc_q);
      A_PER:   rdata_o = DW'(per_q);
      A_CDAT:  rdata_o = DW'(cdat_q);
      default: rdata_o = '0;
    endcase
  end

  assign irq_o     = |(sts_q & ien_q);
  assign ctrl_o    = ctrl_q;
  assign mode_o    = mode_q;
  assign chctl_o   = chctl_q;
  assign per_act_o = per_act_q;
  assign psc_act_o = psc_act_q;
  assign cmp_act_o = cmp_act_q;

  // R4
  ovf_flag_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sts_q[0]) |-> $past(ev_i));
  // R6
  one_shot_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_i && ctrl_q.one_shot) |=> !ctrl_q.cnt_en);
  // R5
  per_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ev_i && !(wr_per && !ctrl_q.per_buf)) |=> $stable(per_act_q));
  // R9
  cap_store_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_evt_i |=> (cdat_q == $past(cnt_i)) && sts_q[1]);
endmodule

// File: rtl/gp_timer.sv
module gp_timer
  import gp_timer_pkg::*;
#(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned AW    = 8,
  parameter int unsigned DW    = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  input  logic          cap_i,
  output logic          cmp_o,
  output logic          irq_o
);
  ctrl_t  ctrl;
  mode_t  mode;
  chctl_t chctl;
  logic [CNT_W-1:0] per_act, psc_act, cmp_act, cnt, cnt_nxt, cnt_wdata;
  logic cnt_wr, sw_req, ev, step, cap_evt, match;

  gp_timer_regs #(.CNT_W(CNT_W), .AW(AW), .DW(DW)) u_regs (
    .clk_i, .rst_ni, .req_i, .we_i, .addr_i, .wdata_i, .rdata_o,
    .ev_i(ev), .cap_evt_i(cap_evt), .match_i(match), .cnt_i(cnt),
    .ctrl_o(ctrl), .mode_o(mode), .chctl_o(chctl),
    .per_act_o(per_act), .psc_act_o(psc_act), .cmp_act_o(cmp_act),
    .cnt_wr_o(cnt_wr), .cnt_wdata_o(cnt_wdata), .sw_req_o(sw_req), .irq_o
  );

  gp_timer_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i, .rst_ni,
    .en_i(ctrl.cnt_en), .ovf_dis_i(ctrl.ovf_dis), .src_sel_i(ctrl.src_sel),
    .sw_req_i(sw_req), .per_i(per_act), .psc_i(psc_act),
    .cnt_wr_i(cnt_wr), .cnt_wdata_i(cnt_wdata),
    .cnt_o(cnt), .cnt_nxt_o(cnt_nxt), .step_o(step), .ev_o(ev)
  );

  gp_timer_chan #(.CNT_W(CNT_W)) u_chan (
    .clk_i, .rst_ni, .cap_i,
    .flt_div_i(ctrl.flt_div), .in_mode_i(mode.in_mode),
    .ch_en_i(chctl.ch_en), .pol_i(chctl.pol),
    .cnt_i(cnt), .cmp_i(cmp_act), .step_i(step), .cnt_nxt_i(cnt_nxt),
    .cap_evt_o(cap_evt), .match_o(match), .cmp_o
  );
endmodule

// File: tb/tb_gp_timer.sv
module tb_gp_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0, cap = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        cmp, irq;
  int n_tests = 0, n_fail = 0;

  always #5 clk = ~clk;

  gp_timer dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .cap_i(cap), .cmp_o(cmp), .irq_o(irq)
  );

  localparam logic [7:0] CTRL = 8'h00, IEN = 8'h0C, STS = 8'h10, SWEV = 8'h14,
                         MODE = 8'h18, CHCTL = 8'h20, CNT = 8'h24, PSC = 8'h28,
                         PER = 8'h2C, CDAT = 8'h34;

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", r, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk); req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; cap = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  function automatic logic [31:0] exp_cnt(int j, int p, int per);
    return 32'((j / (p + 1)) % (per + 1));
  endfunction

  task automatic pulse_count(input logic [31:0] div_bits, output int hits);
    logic [31:0] d;
    hits = 0;
    wr(CTRL, div_bits);
    wr(STS, 0);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk); cap = 1'b1;
      @(negedge clk); cap = 1'b0;
      repeat (4) @(negedge clk);
      rd(STS, d);
      if (d[1]) hits++;
      wr(STS, 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int p, per, m, hits;
    logic [15:0] cv, cm;
    logic pl;
    void'($urandom(32'd20240611));

    // R1 reset state
    do_reset();
    begin
      logic [7:0] offs [10] = '{CTRL, IEN, STS, SWEV, MODE, CHCTL, CNT, PSC, PER, CDAT};
      foreach (offs[i]) begin rd(offs[i], d); chk("R1 reg", d, 0); end
    end
    chk("R1 cmp_o", {31'b0, cmp}, 0);
    chk("R1 irq_o", {31'b0, irq}, 0);

    // R2 reserved bits and decode
    wr(CTRL, 32'hFFFF_FFFF); rd(CTRL, d); chk("R2 ctrl", d, 32'h38F);
    wr(IEN, 32'hFFFF_FFFF);  rd(IEN, d);  chk("R2 ien", d, 32'h3);
    wr(CHCTL, 32'hFFFF_FFFF); rd(CHCTL, d); chk("R2 chctl", d, 32'h3);
    wr(MODE, 32'hFFFF_FFFF); rd(MODE, d); chk("R2 mode", d, 32'h9);
    wr(SWEV, 32'hFFFF_FFFF); rd(SWEV, d); chk("R2 swev", d, 0);
    wr(CTRL, 0);
    wr(CNT, 32'hABCD_1234);  rd(CNT, d);  chk("R2 cnt width", d, 32'h1234);
    rd(8'h04, d); chk("R2 unmapped", d, 0);
    rd(8'h35, d); chk("R2 unaligned", d, 0);

    // R3 random prescaler/period runs
    for (int it = 0; it < 8; it++) begin
      do_reset();
      p = $urandom_range(0, 4); per = $urandom_range(2, 30); m = $urandom_range(0, 150);
      wr(PSC, p); wr(SWEV, 1); wr(PER, per); wr(CTRL, 1);
      repeat (m) @(negedge clk);
      rd(CNT, d);
      chk("R3 count", d, exp_cnt(m + 1, p, per));
    end

    // R4 overflow flag timing, clear, irq
    do_reset();
    wr(IEN, 1); wr(PER, 4); wr(CTRL, 1);
    repeat (3) @(negedge clk);
    rd(STS, d); chk("R4 before wrap", d, 0);
    rd(STS, d); chk("R4 after wrap", d, 1);
    chk("R4 irq set", {31'b0, irq}, 1);
    wr(CTRL, 0);
    wr(STS, 32'hFFFF_FFFF); rd(STS, d); chk("R4 write1 keeps", d, 1);
    wr(STS, 0); rd(STS, d); chk("R4 write0 clears", d, 0);
    chk("R4 irq clear", {31'b0, irq}, 0);

    // R5 buffered period
    do_reset();
    wr(PER, 10); wr(CTRL, 32'h80); wr(CNT, 5); wr(PER, 3); wr(CTRL, 32'h81);
    @(negedge clk);
    rd(CNT, d); chk("R5 buffered", d, 7);
    do_reset();
    wr(PER, 10); wr(CNT, 5); wr(PER, 3); wr(CTRL, 1);
    @(negedge clk);
    rd(CNT, d); chk("R5 live", d, 1);
    rd(PER, d); chk("R5 readback", d, 3);

    // R6 one-cycle mode
    do_reset();
    wr(PER, 4); wr(CTRL, 32'h9);
    repeat (20) @(negedge clk);
    rd(CTRL, d); chk("R6 en cleared", d, 32'h8);
    rd(CNT, d);  chk("R6 cnt zero", d, 0);
    rd(STS, d);  chk("R6 flag", d, 1);

    // R7 event source and gating
    do_reset();
    wr(PER, 100); wr(CNT, 7); wr(CTRL, 32'h4); wr(SWEV, 1);
    rd(CNT, d); chk("R7 src_sel cnt", d, 7);
    rd(STS, d); chk("R7 src_sel flag", d, 0);
    wr(CTRL, 0); wr(SWEV, 1);
    rd(CNT, d); chk("R7 sw cnt", d, 0);
    rd(STS, d); chk("R7 sw flag", d, 1);
    wr(STS, 0); wr(PER, 2); wr(CTRL, 32'h3);
    repeat (10) @(negedge clk);
    wr(SWEV, 1);
    rd(STS, d); chk("R7 disabled flag", d, 0);
    rd(CNT, d); chk("R7 still wraps", {31'b0, d <= 2}, 1);

    // R8 prescaler buffered
    do_reset();
    wr(PER, 32'hFFFF); wr(PSC, 3); wr(CTRL, 1);
    repeat (7) @(negedge clk);
    rd(CNT, d); chk("R8 old psc", d, 8);
    rd(PSC, d); chk("R8 readback", d, 3);
    wr(CTRL, 0); wr(SWEV, 1); wr(CTRL, 1);
    repeat (7) @(negedge clk);
    rd(CNT, d); chk("R8 new psc", d, 2);

    // R9 capture, both polarities, random values
    do_reset();
    wr(MODE, 1); wr(CHCTL, 1);
    for (int it = 0; it < 5; it++) begin
      cv = 16'($urandom);
      wr(CNT, {16'h0, cv}); wr(STS, 0);
      @(negedge clk); cap = 1'b1;
      repeat (6) @(negedge clk); cap = 1'b0;
      repeat (6) @(negedge clk);
      rd(CDAT, d); chk("R9 rise capture", d, {16'h0, cv});
      rd(STS, d);  chk("R9 flag", d, 2);
    end
    wr(CHCTL, 3); wr(CNT, 32'h42); wr(STS, 0);
    @(negedge clk); cap = 1'b1;
    repeat (6) @(negedge clk);
    rd(STS, d); chk("R9 pol1 ignores rise", d, 0);
    cap = 1'b0;
    repeat (6) @(negedge clk);
    rd(CDAT, d); chk("R9 fall capture", d, 32'h42);
    wr(CDAT, 32'h5555); rd(CDAT, d); chk("R9 write ignored", d, 32'h42);

    // R10 sampling divide
    do_reset();
    wr(MODE, 1); wr(CHCTL, 1);
    pulse_count(32'h200, hits); chk("R10 div4 hits", hits, 1);
    pulse_count(32'h000, hits); chk("R10 div1 hits", hits, 4);

    // R11 compare output, random
    do_reset();
    for (int it = 0; it < 20; it++) begin
      cv = 16'($urandom_range(0, 63)); cm = 16'($urandom_range(0, 63)); pl = 1'($urandom);
      wr(CHCTL, {30'b0, pl, 1'b1}); wr(CDAT, {16'h0, cm}); wr(CNT, {16'h0, cv});
      #1 chk("R11 cmp_o", {31'b0, cmp}, {31'b0, pl ^ (cv < cm)});
    end
    wr(CHCTL, 32'h2); #1 chk("R11 disabled", {31'b0, cmp}, 0);
    wr(CHCTL, 32'h3); wr(MODE, 1); #1 chk("R11 input mode", {31'b0, cmp}, 0);

    // R12 compare buffering
    do_reset();
    wr(CHCTL, 1); wr(CDAT, 10); wr(MODE, 32'h8); wr(CDAT, 3); wr(CNT, 5);
    #1 chk("R12 old compare", {31'b0, cmp}, 1);
    rd(CDAT, d); chk("R12 readback", d, 3);
    wr(SWEV, 1); wr(CNT, 5);
    #1 chk("R12 new compare", {31'b0, cmp}, 0);

    // R13 match flag and channel irq
    do_reset();
    wr(IEN, 2); wr(PER, 255); wr(CHCTL, 1); wr(CDAT, 5); wr(CTRL, 1);
    repeat (10) @(negedge clk);
    rd(STS, d); chk("R13 match flag", d, 2);
    chk("R4 irq channel", {31'b0, irq}, 1);
    wr(CTRL, 0); wr(STS, 0); wr(CNT, 0); wr(CDAT, 200); wr(CTRL, 1);
    repeat (10) @(negedge clk);
    rd(STS, d); chk("R13 no match", d, 0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule